// File: doc/BRIEF.md
# Training-Set Replay and Squared-Error Scorer

This block sits in front of a fixed evolvable-network datapath so that one circuit can be trained for many different pattern-detection tasks by loading data rather than rebuilding logic. A byte stream delivers a small header and then a set of example images. Each image is an 8x8 grid of 8-bit pixels flattened row after row into 64 elements. The block keeps the whole set in local storage and reports when it is complete.

On a start request the block clears the external network once and then replays every stored example onto the network's external inputs, each for a programmable number of ticks. All positive examples come first and all negative examples follow. With every tick it presents a target value chosen by the example's class. It compares the network's returned output with that target and accumulates the squared difference over the whole run. At the end it converts the total into a reciprocal fitness figure for the genetic search engine, which sits outside this block.

Top module: `exseq_scorer`

## Requirements
- R1: The stream is taken in this order: the positive count P, then the negative count M, then the tick count C, then (P+M)*64 element bytes, example by example, element 0 first. `load_done` reads 1 from the clock edge that accepts the last byte of the stream. When P+M is 0, that last byte is C. P+M must not exceed the number of storage slots.
- R2: A byte is consumed only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while an evaluation runs and high otherwise. Accepting the first header byte of a new stream clears `load_done`.
- R3: `eval_start` has no effect unless `load_done` is 1 and no evaluation is running.
- R4: An accepted start drives `net_clr` high for exactly one cycle, before the first tick. It is never raised again during that run, including between examples.
- R5: Every example is held for Ce consecutive `net_tick` cycles, where Ce equals C, or 1 when C is 0. Examples 0..P-1 (the positives) are presented before examples P..P+M-1, so one run has Ce*(P+M) ticks.
- R6: During a tick, element k of the current example is on `neuron_ext[8k+7:8k]`. Neuron j therefore receives elements 4j..4j+3 on bits [32j+31:32j].
- R7: `net_target` equals `cfg_tgt_hi` on ticks of positive examples and `cfg_tgt_lo` on ticks of negative examples. Both are signed two's complement, for example +0.8 is 13107 in Q1.14.
- R8: `err_sum` is cleared at the start of a run. It then adds (target - net_out)^2, computed as signed values from `net_out` sampled in each tick cycle.
- R9: At the end of a run, `eval_done` pulses for one cycle with `fitness` = floor((2^48-1)/(err_sum+1)). `eval_busy` is high in that cycle and low on the next.
- R10: After reset, `in_ready`=1, and `load_done`, `eval_busy`, `eval_done`, `net_clr`, `net_tick` and `err_sum` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a stream byte |
| load_done | output | 1 | Complete training set stored |
| cfg_tgt_hi | input | 16 | Signed target for positive examples |
| cfg_tgt_lo | input | 16 | Signed target for negative examples |
| eval_start | input | 1 | Request an evaluation run |
| eval_busy | output | 1 | Evaluation in progress |
| eval_done | output | 1 | One-cycle end-of-run pulse |
| net_clr | output | 1 | Clear the network state |
| net_tick | output | 1 | Network advances one tick |
| neuron_ext | output | 512 | External inputs, 4 elements per neuron |
| net_target | output | 16 | Target for the current tick |
| net_out | input | 16 | Signed output returned by the network |
| err_sum | output | 48 | Accumulated squared error |
| fitness | output | 48 | Reciprocal fitness of the last run |

## Verification
If the element or example counters were wrong inside the store, this would show on `neuron_ext` in the first tick that presents the damaged slot. It would also show in `load_done` rising too early or too late relative to the final byte. A broken tick or example counter in the replay engine changes when the target flips from high to low, or changes the total tick count. Either fault shifts `err_sum` by the end of the run and so corrupts `fitness` at `eval_done`. The bench compares every tick's vector and target against its own copy of the training set, so most state faults are caught within one cycle of their first visible effect.

// File: rtl/exseq_pkg.sv
package exseq_pkg;

    // Stream parser phases; order follows the header layout of the stream.
    typedef enum logic [1:0] {
        LD_POS_CNT = 2'd0,
        LD_NEG_CNT = 2'd1,
        LD_TICKS   = 2'd2,
        LD_ELEMS   = 2'd3
    } ld_state_e;

    // Replay engine phases.
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_CLEAR  = 2'd1,
        EV_RUN    = 2'd2,
        EV_DIVIDE = 2'd3
    } ev_state_e;

endpackage

// File: rtl/exseq_loader.sv
module exseq_loader #(
    parameter int EL_W   = 8,
    parameter int NUM_EL = 64,
    parameter int MAX_EX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_en,
    input  logic                       in_valid,
    input  logic [EL_W-1:0]            in_data,
    input  logic [$clog2(MAX_EX)-1:0]  rd_idx,
    output logic [EL_W-1:0]            n_pos,
    output logic [EL_W-1:0]            n_neg,
    output logic [EL_W-1:0]            ticks,
    output logic                       load_done,
    output logic [NUM_EL*EL_W-1:0]     rd_vec
);
    import exseq_pkg::*;

    localparam int IDX_W    = $clog2(MAX_EX);
    localparam int EL_IDX_W = $clog2(NUM_EL);
    localparam int VEC_W    = NUM_EL * EL_W;
    localparam int CNT_W    = EL_W;

    typedef struct packed {
        ld_state_e           st;
        logic [EL_W-1:0]     n_pos;
        logic [EL_W-1:0]     n_neg;
        logic [EL_W-1:0]     ticks;
        logic [IDX_W-1:0]    ex;
        logic [EL_IDX_W-1:0] el;
        logic                done;
    } ld_t;

    ld_t              q, d;
    logic             take;
    logic             wr_en;
    logic [CNT_W:0]   total;
    logic [CNT_W:0]   last_ex;
    logic [VEC_W-1:0] mem_q [MAX_EX];

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        take    = in_valid & accept_en;
        total   = {1'b0, q.n_pos} + {1'b0, q.n_neg};
        last_ex = total - 1'b1;
        if (take) begin
            case (q.st)
                LD_POS_CNT: begin
                    d.n_pos = in_data;
                    d.done  = 1'b0;
                    d.st    = LD_NEG_CNT;
                end
                LD_NEG_CNT: begin
                    d.n_neg = in_data;
                    d.st    = LD_TICKS;
                end
                LD_TICKS: begin
                    d.ticks = in_data;
                    d.ex    = '0;
                    d.el    = '0;
                    if (total == '0) begin
                        d.done = 1'b1;
                        d.st   = LD_POS_CNT;
                    end else begin
                        d.st = LD_ELEMS;
                    end
                end
                LD_ELEMS: begin
                    wr_en = 1'b1;
                    if (q.el == EL_IDX_W'(NUM_EL - 1)) begin
                        d.el = '0;
                        if ((CNT_W + 1)'(q.ex) == last_ex) begin
                            d.done = 1'b1;
                            d.st   = LD_POS_CNT;
                        end else begin
                            d.ex = q.ex + 1'b1;
                        end
                    end else begin
                        d.el = q.el + 1'b1;
                    end
                end
                default: d.st = LD_POS_CNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Example store: one row per example, written one element per accepted byte.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[q.ex][q.el*EL_W +: EL_W] <= in_data;
        end
    end

    assign rd_vec    = mem_q[rd_idx];
    assign n_pos     = q.n_pos;
    assign n_neg     = q.n_neg;
    assign ticks     = q.ticks;
    assign load_done = q.done;

endmodule

// File: rtl/exseq_sequencer.sv
module exseq_sequencer #(
    parameter int CNT_W  = 8,
    parameter int MAX_EX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       load_done,
    input  logic [CNT_W-1:0]           n_pos,
    input  logic [CNT_W-1:0]           n_neg,
    input  logic [CNT_W-1:0]           ticks,
    input  logic                       div_done,
    output logic                       busy,
    output logic                       net_clr,
    output logic                       net_tick,
    output logic                       is_pos,
    output logic [$clog2(MAX_EX)-1:0]  ex_idx,
    output logic                       div_go
);
    import exseq_pkg::*;

    localparam int IDX_W = $clog2(MAX_EX);

    typedef struct packed {
        ev_state_e        st;
        logic [IDX_W-1:0] ex;
        logic [CNT_W-1:0] tk;
        logic             go;
    } ev_t;

    ev_t            q, d;
    logic [CNT_W:0] total;
    logic [CNT_W:0] last_ex;
    logic [CNT_W-1:0] tk_last;

    always_comb begin
        d       = q;
        d.go    = 1'b0;
        total   = {1'b0, n_pos} + {1'b0, n_neg};
        last_ex = total - 1'b1;
        tk_last = (ticks == '0) ? '0 : ticks - 1'b1;
        case (q.st)
            EV_IDLE: begin
                if (start && load_done) begin
                    d.st = EV_CLEAR;
                end
            end
            EV_CLEAR: begin
                d.ex = '0;
                d.tk = '0;
                if (total == '0) begin
                    d.st = EV_DIVIDE;
                    d.go = 1'b1;
                end else begin
                    d.st = EV_RUN;
                end
            end
            EV_RUN: begin
                if (q.tk == tk_last) begin
                    d.tk = '0;
                    if ((CNT_W + 1)'(q.ex) == last_ex) begin
                        d.st = EV_DIVIDE;
                        d.go = 1'b1;
                    end else begin
                        d.ex = q.ex + 1'b1;
                    end
                end else begin
                    d.tk = q.tk + 1'b1;
                end
            end
            EV_DIVIDE: begin
                if (div_done) begin
                    d.st = EV_IDLE;
                end
            end
            default: d.st = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != EV_IDLE);
    assign net_clr  = (q.st == EV_CLEAR);
    assign net_tick = (q.st == EV_RUN);
    assign is_pos   = ((CNT_W + 1)'(q.ex) < {1'b0, n_pos});
    assign ex_idx   = q.ex;
    assign div_go   = q.go;

endmodule

// File: rtl/exseq_err_acc.sv
module exseq_err_acc #(
    parameter int OUT_W = 16,
    parameter int SUM_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [OUT_W-1:0] target,
    input  logic [OUT_W-1:0] net_out,
    output logic [SUM_W-1:0] sum
);
    localparam int SQ_W = 2 * OUT_W + 2;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
    } acc_t;

    acc_t                    q, d;
    logic signed [OUT_W:0]   diff;
    logic signed [SQ_W-1:0]  sq;
    logic [SQ_W-1:0]         sq_u;

    always_comb begin
        d    = q;
        diff = $signed({target[OUT_W-1], target}) - $signed({net_out[OUT_W-1], net_out});
        sq   = SQ_W'(diff) * SQ_W'(diff);
        sq_u = sq;
        if (clr) begin
            d.sum = '0;
        end else if (en) begin
            d.sum = q.sum + SUM_W'(sq_u);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sum = q.sum;

endmodule

// File: rtl/exseq_recip.sv
module exseq_recip #(
    parameter int SUM_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SUM_W-1:0] den,
    output logic             done,
    output logic [SUM_W-1:0] quot
);
    localparam int CW = $clog2(SUM_W);

    // Bit-serial restoring division of an all-ones numerator by (den + 1).
    typedef struct packed {
        logic             run;
        logic [CW-1:0]    cnt;
        logic [SUM_W-1:0] rem;
        logic [SUM_W-1:0] quo;
        logic [SUM_W:0]   dvs;
        logic             done;
    } dv_t;

    dv_t            q, d;
    logic [SUM_W:0] trial;
    logic           fits;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, 1'b1};
        fits   = (trial >= q.dvs);
        if (go) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.rem = '0;
            d.quo = '0;
            d.dvs = {1'b0, den} + 1'b1;
        end else if (q.run) begin
            d.rem = fits ? SUM_W'(trial - q.dvs) : trial[SUM_W-1:0];
            d.quo = {q.quo[SUM_W-2:0], fits};
            if (q.cnt == CW'(SUM_W - 1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign quot = q.quo;

endmodule

// File: rtl/exseq_scorer.sv
module exseq_scorer #(
    parameter int EL_W    = 8,
    parameter int NEURONS = 16,
    parameter int FANIN   = 4,
    parameter int MAX_EX  = 8,
    parameter int OUT_W   = 16,
    parameter int SUM_W   = 48
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [EL_W-1:0]                  in_data,
    output logic                             in_ready,
    output logic                             load_done,
    input  logic [OUT_W-1:0]                 cfg_tgt_hi,
    input  logic [OUT_W-1:0]                 cfg_tgt_lo,
    input  logic                             eval_start,
    output logic                             eval_busy,
    output logic                             eval_done,
    output logic                             net_clr,
    output logic                             net_tick,
    output logic [NEURONS*FANIN*EL_W-1:0]    neuron_ext,
    output logic [OUT_W-1:0]                 net_target,
    input  logic [OUT_W-1:0]                 net_out,
    output logic [SUM_W-1:0]                 err_sum,
    output logic [SUM_W-1:0]                 fitness
);
    localparam int NUM_EL = NEURONS * FANIN;
    localparam int VEC_W  = NUM_EL * EL_W;
    localparam int GRP_W  = FANIN * EL_W;
    localparam int IDX_W  = $clog2(MAX_EX);

    logic [EL_W-1:0]  n_pos, n_neg, ticks;
    logic [IDX_W-1:0] ex_idx;
    logic [VEC_W-1:0] rd_vec;
    logic             busy, is_pos, div_go, div_done;

    exseq_loader #(
        .EL_W   (EL_W),
        .NUM_EL (NUM_EL),
        .MAX_EX (MAX_EX)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_en (!busy),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .rd_idx    (ex_idx),
        .n_pos     (n_pos),
        .n_neg     (n_neg),
        .ticks     (ticks),
        .load_done (load_done),
        .rd_vec    (rd_vec)
    );

    exseq_sequencer #(
        .CNT_W  (EL_W),
        .MAX_EX (MAX_EX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eval_start),
        .load_done (load_done),
        .n_pos     (n_pos),
        .n_neg     (n_neg),
        .ticks     (ticks),
        .div_done  (div_done),
        .busy      (busy),
        .net_clr   (net_clr),
        .net_tick  (net_tick),
        .is_pos    (is_pos),
        .ex_idx    (ex_idx),
        .div_go    (div_go)
    );

    assign net_target = is_pos ? cfg_tgt_hi : cfg_tgt_lo;

    exseq_err_acc #(
        .OUT_W (OUT_W),
        .SUM_W (SUM_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (net_clr),
        .en      (net_tick),
        .target  (net_target),
        .net_out (net_out),
        .sum     (err_sum)
    );

    exseq_recip #(
        .SUM_W (SUM_W)
    ) u_recip (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .den   (err_sum),
        .done  (div_done),
        .quot  (fitness)
    );

    // Neuron j takes the FANIN consecutive elements starting at j*FANIN.
    for (genvar j = 0; j < NEURONS; j++) begin : g_route
        assign neuron_ext[j*GRP_W +: GRP_W] = rd_vec[j*GRP_W +: GRP_W];
    end

    assign in_ready  = !busy;
    assign eval_busy = busy;
    assign eval_done = div_done;

endmodule

// File: rtl/exseq_scorer_chk.sv
module exseq_scorer_chk #(
    parameter int OUT_W = 16,
    parameter int SUM_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             load_done,
    input logic             eval_busy,
    input logic             eval_done,
    input logic             net_clr,
    input logic             net_tick,
    input logic [OUT_W-1:0] net_target,
    input logic [OUT_W-1:0] cfg_tgt_hi,
    input logic [OUT_W-1:0] cfg_tgt_lo,
    input logic [SUM_W-1:0] err_sum
);

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_busy |-> !in_ready);

    p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_busy && !load_done) |=> !eval_busy);

    p_clr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eval_busy) |-> net_clr);

    p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        net_clr |=> !net_clr);

    p_tick_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        net_tick |-> (eval_busy && !eval_done));

    p_target_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        net_tick |-> (net_target == cfg_tgt_hi || net_target == cfg_tgt_lo));

    p_err_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        net_tick |=> (err_sum >= $past(err_sum)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eval_done |=> (!eval_done && !eval_busy));

    p_done_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eval_done |-> eval_busy);

endmodule

bind exseq_scorer exseq_scorer_chk #(
    .OUT_W (OUT_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .load_done  (load_done),
    .eval_busy  (eval_busy),
    .eval_done  (eval_done),
    .net_clr    (net_clr),
    .net_tick   (net_tick),
    .net_target (net_target),
    .cfg_tgt_hi (cfg_tgt_hi),
    .cfg_tgt_lo (cfg_tgt_lo),
    .err_sum    (err_sum)
);

// File: tb/exseq_scorer_tb.sv
module exseq_scorer_tb;
    localparam int NUM_EL = 64;
    localparam int MAX_EX = 8;
    localparam int VEC_W  = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready, load_done;
    logic [15:0]       cfg_tgt_hi = '0, cfg_tgt_lo = '0;
    logic              eval_start = 1'b0;
    logic              eval_busy, eval_done, net_clr, net_tick;
    logic [VEC_W-1:0]  neuron_ext;
    logic [15:0]       net_target, net_out;
    logic [47:0]       err_sum, fitness;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] bv [MAX_EX][NUM_EL];

    always #10 clk = ~clk;

    exseq_scorer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .load_done(load_done), .cfg_tgt_hi(cfg_tgt_hi),
        .cfg_tgt_lo(cfg_tgt_lo), .eval_start(eval_start), .eval_busy(eval_busy),
        .eval_done(eval_done), .net_clr(net_clr), .net_tick(net_tick),
        .neuron_ext(neuron_ext), .net_target(net_target), .net_out(net_out),
        .err_sum(err_sum), .fitness(fitness)
    );

    // Stand-in network: output depends on the first and last pixel presented.
    function automatic logic [15:0] model(input logic [7:0] first, input logic [7:0] last);
        int a = int'($signed(first));
        int b = int'($signed(last));
        return 16'(a * 64 + b);
    endfunction

    assign net_out = model(neuron_ext[7:0], neuron_ext[VEC_W-1 -: 8]);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    // Stream a training set; gaps insert idle cycles carrying junk data.
    task automatic load_set(input int n1, input int n2, input int c, input int seed,
                            input bit gaps, input bit reload);
        logic [7:0] stream [$];
        int total = n1 + n2;
        for (int ex = 0; ex < total; ex++)
            for (int k = 0; k < NUM_EL; k++)
                bv[ex][k] = 8'(seed * 29 + ex * 53 + k * 7 + (ex * k) % 5);
        stream.push_back(8'(n1));
        stream.push_back(8'(n2));
        stream.push_back(8'(c));
        for (int ex = 0; ex < total; ex++)
            for (int k = 0; k < NUM_EL; k++)
                stream.push_back(bv[ex][k]);
        for (int i = 0; i < stream.size(); i++) begin
            if (gaps && (i % 5 == 4)) begin
                in_valid = 1'b0;
                in_data  = 8'hA5;
                @(negedge clk);
            end
            if (i == stream.size() - 1)
                check(load_done == 1'b0, "R1 load_done low before last byte", load_done, 0);
            in_valid = 1'b1;
            in_data  = stream[i];
            @(negedge clk);
            if (reload && i == 0)
                check(load_done == 1'b0, "R2 first byte of new stream clears load_done", load_done, 0);
        end
        in_valid = 1'b0;
        check(load_done == 1'b1, "R1 load_done after last byte", load_done, 1);
    endtask

    task automatic run_eval(input int n1, input int n2, input int c,
                            input logic [15:0] hi, input logic [15:0] lo, input bit stray);
        int ceff = (c == 0) ? 1 : c;
        int total = n1 + n2;
        longint exp_err = 0;
        int tks = 0;
        int clrs = 0;
        bit clr_late = 0;
        bit done = 0;
        bit rdy_bad = 0;
        logic [63:0] fexp;
        cfg_tgt_hi = hi;
        cfg_tgt_lo = lo;
        eval_start = 1'b1;
        @(negedge clk);
        eval_start = 1'b0;
        for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
            if (net_clr) begin
                clrs++;
                if (tks > 0) clr_late = 1;
            end
            if (in_ready) rdy_bad = 1;
            if (net_tick) begin
                int ex = tks / ceff;
                int bad_k = -1;
                logic [15:0] tgt = (ex < n1) ? hi : lo;
                int outv;
                int diff;
                for (int k = NUM_EL - 1; k >= 0; k--)
                    if (neuron_ext[k*8 +: 8] !== bv[ex][k]) bad_k = k;
                if (bad_k >= 0)
                    check(0, "R6 element routing", neuron_ext[bad_k*8 +: 8], bv[ex][bad_k]);
                else
                    check(1, "R6 element routing", 0, 0);
                check(net_target == tgt, "R7 target by class", $signed(net_target), $signed(tgt));
                outv = int'($signed(model(bv[ex][0], bv[ex][NUM_EL-1])));
                diff = int'($signed(tgt)) - outv;
                exp_err += longint'(diff) * longint'(diff);
                tks++;
            end
            if (eval_done) begin
                done = 1;
            end else begin
                if (stray && cyc == 2) begin
                    eval_start = 1'b1;
                    in_valid   = 1'b1;
                    in_data    = 8'h00;
                end else begin
                    eval_start = 1'b0;
                    in_valid   = 1'b0;
                end
                @(negedge clk);
            end
        end
        check(done, "R9 eval_done seen", done, 1);
        check(tks == ceff * total, "R5 tick count", tks, ceff * total);
        check(clrs == 1 && !clr_late, "R4 single clear before first tick", clrs, 1);
        check(!rdy_bad, "R2 in_ready low while busy", rdy_bad, 0);
        check(err_sum == 48'(exp_err), "R8 squared error sum", longint'(err_sum), exp_err);
        fexp = 64'h0000_FFFF_FFFF_FFFF / (64'(exp_err) + 64'd1);
        check(fitness == fexp[47:0], "R9 fitness", longint'(fitness), longint'(fexp));
        check(eval_busy == 1'b1, "R9 busy during done cycle", eval_busy, 1);
        @(negedge clk);
        check(!eval_busy && !eval_done, "R9 done is one pulse and run ends",
              {eval_busy, eval_done}, 0);
        check(load_done == 1'b1, "R2 stray byte during run not consumed", load_done, 1);
    endtask

    task automatic t_reset();
        check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
        check(!load_done && !eval_busy && !eval_done, "R10 status after reset",
              {load_done, eval_busy, eval_done}, 0);
        check(!net_clr && !net_tick, "R10 network controls after reset", {net_clr, net_tick}, 0);
        check(err_sum == '0, "R10 err_sum after reset", longint'(err_sum), 0);
    endtask

    task automatic t_start_unloaded();
        bit moved = 0;
        eval_start = 1'b1;
        @(negedge clk);
        eval_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (eval_busy || net_clr || net_tick) moved = 1;
            @(negedge clk);
        end
        check(!moved, "R3 start ignored before load", moved, 0);
    endtask

    task automatic t_basic();
        load_set(2, 1, 3, 1, 1'b1, 1'b0);
        run_eval(2, 1, 3, 16'd13107, 16'(-13107), 1'b1);
    endtask

    task automatic t_reload_c_zero();
        load_set(1, 3, 0, 7, 1'b0, 1'b1);
        run_eval(1, 3, 0, 16'd8000, 16'(-2000), 1'b0);
    endtask

    task automatic t_empty_set();
        load_set(0, 0, 5, 2, 1'b0, 1'b1);
        run_eval(0, 0, 5, 16'd13107, 16'(-13107), 1'b0);
    endtask

    task automatic t_full_store();
        load_set(4, 4, 2, 3, 1'b1, 1'b1);
        run_eval(4, 4, 2, 16'd13107, 16'(-13107), 1'b0);
        run_eval(4, 4, 2, 16'(-500), 16'd9000, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_unloaded();
        t_basic();
        t_reload_c_zero();
        t_empty_set();
        t_full_store();
        summary();
        $finish;
    end

endmodule